// File: doc/BRIEF.md
# Keyed-Enable Watchdog Timer

This block is a supervision counter that runs from a slow 1 kHz reference tick and asks the system to reset if software stops restarting it. Each tick in which the block is running adds one to the count. A write to the restart register sets the count back to zero. If the count reaches the warning mark, the block sends a one-cycle early-warning pulse for the non-maskable interrupt line. If the count reaches the timeout mark, it sends a one-cycle reset request and then freezes. The defaults are 1792 ticks for the warning and 2048 ticks for the timeout.

Software cannot turn the counter on or off with a single stray write. It first writes an unlock code to the key register. The very next write must go to the command register and set the matching bit. Any other write in between cancels the unlock. While the debugger holds the CPU halted, the count can be frozen through a configuration input. If the tick stops, counting also stops.

Top module: `kwdt_top`

## Requirements
- R1: After the asynchronous reset the watchdog is disabled, the count is zero and both `nmi_o` and `rst_req_o` are low. While disabled, neither output ever pulses.
- R2: While enabled, the count advances by exactly one in each clock cycle where `tick_i` is high. It does not change in any cycle where `tick_i` is low.
- R3: A write of 0xEABE to the key register (address 0), followed immediately by a write to the command register (address 1) with bit 0 set, enables the watchdog.
- R4: A write of 0xDEAD to the key register, followed immediately by a command write with bit 1 set, disables the watchdog and clears the count. A 0xEABE key followed by a bit-1 command does not disable it.
- R5: A command write that does not immediately follow the matching key write is ignored. Any write other than a matching key write clears the unlocked state.
- R6: Any write to the restart register (address 2) clears the count to zero. In the same cycle it takes priority over a tick.
- R7: `nmi_o` is high for exactly one cycle: the cycle after the tick that brings the count to WARN_TICKS.
- R8: `rst_req_o` is high for exactly one cycle: the cycle after the tick that brings the count to TIMEOUT_TICKS. After that the count is frozen and neither output pulses again until reset, whatever is written.
- R9: While `pause_cfg_i` and `dbg_halt_i` are both high, ticks are ignored. `dbg_halt_i` alone does not stop counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| arst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle strobe from the 1 kHz reference |
| dbg_halt_i | input | 1 | CPU held halted by the debugger |
| pause_cfg_i | input | 1 | Freeze counting while the CPU is debug-halted |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W | Register address: 0 key, 1 command, 2 restart |
| wr_data_i | input | DATA_W | Write data |
| nmi_o | output | 1 | Early-warning interrupt pulse |
| rst_req_o | output | 1 | Watchdog reset request pulse |

## Verification
The bench builds the block with TIMEOUT_TICKS=64 and WARN_TICKS=48, keeping the default key codes and register addresses. With these values, full expiry, the frozen state after expiry and the gap between warning and expiry are all reached within a few hundred cycles. This makes it practical to run each scenario several times with ticks on every cycle and with sparse ticks. A behavioural reference model in the bench predicts both outputs on every cycle.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;

  typedef enum logic [1:0] {
    ARM_NONE = 2'd0,
    ARM_ON   = 2'd1,
    ARM_OFF  = 2'd2
  } arm_e;

  typedef struct packed {
    logic any;       // some write happened
    logic key_on;    // key register written with the enable code
    logic key_off;   // key register written with the disable code
    logic cmd;       // command register written
    logic want_on;   // command enable bit
    logic want_off;  // command disable bit
    logic kick;      // restart register written
  } wr_evt_t;

  // Count after one step: restart wins, then a running tick adds one.
  function automatic logic [31:0] step_count(input logic [31:0] cur,
                                             input logic clr,
                                             input logic run);
    if (clr)      return 32'd0;
    else if (run) return cur + 32'd1;
    else          return cur;
  endfunction

  // True when a step lands exactly on a mark.
  function automatic logic lands_on(input logic [31:0] nxt,
                                    input logic run,
                                    input logic clr,
                                    input logic [31:0] mark);
    return run && !clr && (nxt == mark);
  endfunction

endpackage

// File: rtl/kwdt_regdec.sv
module kwdt_regdec
  import kwdt_pkg::*;
#(
  parameter int unsigned ADDR_W    = 4,
  parameter int unsigned DATA_W    = 16,
  parameter logic [DATA_W-1:0] KEY_ON  = 16'hEABE,
  parameter logic [DATA_W-1:0] KEY_OFF = 16'hDEAD,
  parameter int unsigned A_KEY     = 0,
  parameter int unsigned A_CMD     = 1,
  parameter int unsigned A_KICK    = 2,
  parameter int unsigned BIT_ON    = 0,
  parameter int unsigned BIT_OFF   = 1
) (
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output wr_evt_t           evt_o
);

  localparam logic [ADDR_W-1:0] AK = ADDR_W'(A_KEY);
  localparam logic [ADDR_W-1:0] AC = ADDR_W'(A_CMD);
  localparam logic [ADDR_W-1:0] AR = ADDR_W'(A_KICK);

  logic hit_key, hit_cmd, hit_kick;

  always_comb begin
    hit_key  = wr_en_i && (wr_addr_i == AK);
    hit_cmd  = wr_en_i && (wr_addr_i == AC);
    hit_kick = wr_en_i && (wr_addr_i == AR);

    evt_o          = '0;
    evt_o.any      = wr_en_i;
    evt_o.key_on   = hit_key && (wr_data_i == KEY_ON);
    evt_o.key_off  = hit_key && (wr_data_i == KEY_OFF);
    evt_o.cmd      = hit_cmd;
    evt_o.want_on  = hit_cmd && wr_data_i[BIT_ON];
    evt_o.want_off = hit_cmd && wr_data_i[BIT_OFF];
    evt_o.kick     = hit_kick;
  end

endmodule

// File: rtl/kwdt_keyguard.sv
module kwdt_keyguard
  import kwdt_pkg::*;
(
  input  logic    clk_i,
  input  logic    arst_ni,
  input  wr_evt_t evt_i,
  output logic    en_o,
  output logic    go_off_o
);

  arm_e arm_q, arm_d;
  logic en_q, en_d;
  logic go_on;

  always_comb begin
    go_on    = evt_i.want_on  && (arm_q == ARM_ON);
    go_off_o = evt_i.want_off && (arm_q == ARM_OFF);

    // Each write re-decides the unlock state; only a matching key arms it.
    if (evt_i.key_on)       arm_d = ARM_ON;
    else if (evt_i.key_off) arm_d = ARM_OFF;
    else if (evt_i.any)     arm_d = ARM_NONE;
    else                    arm_d = arm_q;

    if (go_on)         en_d = 1'b1;
    else if (go_off_o) en_d = 1'b0;
    else               en_d = en_q;
  end

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) begin
      arm_q <= ARM_NONE;
      en_q  <= 1'b0;
    end else begin
      arm_q <= arm_d;
      en_q  <= en_d;
    end
  end

  assign en_o = en_q;

endmodule

// File: rtl/kwdt_counter.sv
module kwdt_counter
  import kwdt_pkg::*;
#(
  parameter int unsigned TIMEOUT_TICKS = 2048,
  parameter int unsigned WARN_TICKS    = 1792,
  parameter int unsigned CNT_W         = 12
) (
  input  logic             clk_i,
  input  logic             arst_ni,
  input  logic             tick_i,
  input  logic             dbg_halt_i,
  input  logic             pause_cfg_i,
  input  logic             en_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] count_o,
  output logic             run_o,
  output logic             expired_o,
  output logic             nmi_o,
  output logic             rst_req_o
);

  logic [CNT_W-1:0] cnt_q;
  logic [31:0]      cnt_nxt;
  logic             exp_q, nmi_q, rst_q;
  logic             hit_warn, hit_to, paused;

  always_comb begin
    paused   = pause_cfg_i && dbg_halt_i;
    run_o    = en_i && tick_i && !paused && !exp_q;
    cnt_nxt  = step_count(32'(cnt_q), clr_i, run_o);
    hit_warn = lands_on(cnt_nxt, run_o, clr_i, 32'(WARN_TICKS));
    hit_to   = lands_on(cnt_nxt, run_o, clr_i, 32'(TIMEOUT_TICKS));
  end

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) begin
      cnt_q <= '0;
      exp_q <= 1'b0;
      nmi_q <= 1'b0;
      rst_q <= 1'b0;
    end else if (exp_q) begin
      nmi_q <= 1'b0;
      rst_q <= 1'b0;
    end else begin
      cnt_q <= cnt_nxt[CNT_W-1:0];
      nmi_q <= hit_warn;
      rst_q <= hit_to;
      exp_q <= hit_to;
    end
  end

  assign count_o   = cnt_q;
  assign expired_o = exp_q;
  assign nmi_o     = nmi_q;
  assign rst_req_o = rst_q;

endmodule

// File: rtl/kwdt_top.sv
module kwdt_top
  import kwdt_pkg::*;
#(
  parameter int unsigned TIMEOUT_TICKS = 2048,
  parameter int unsigned WARN_TICKS    = 1792,
  parameter int unsigned ADDR_W        = 4,
  parameter int unsigned DATA_W        = 16,
  parameter logic [DATA_W-1:0] KEY_ON  = 16'hEABE,
  parameter logic [DATA_W-1:0] KEY_OFF = 16'hDEAD
) (
  input  logic              clk_i,
  input  logic              arst_ni,
  input  logic              tick_i,
  input  logic              dbg_halt_i,
  input  logic              pause_cfg_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              nmi_o,
  output logic              rst_req_o
);

  localparam int unsigned CNT_W = $clog2(TIMEOUT_TICKS + 1);

  // Named internal events, brought out for the checker.
  wr_evt_t          evt;
  logic             en;
  logic             go_off;
  logic             clr;
  logic             run;
  logic             expired;
  logic [CNT_W-1:0] count;

  kwdt_regdec #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .KEY_ON (KEY_ON),
    .KEY_OFF(KEY_OFF)
  ) u_dec (
    .wr_en_i  (wr_en_i),
    .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i),
    .evt_o    (evt)
  );

  kwdt_keyguard u_guard (
    .clk_i   (clk_i),
    .arst_ni (arst_ni),
    .evt_i   (evt),
    .en_o    (en),
    .go_off_o(go_off)
  );

  assign clr = evt.kick || go_off;

  kwdt_counter #(
    .TIMEOUT_TICKS(TIMEOUT_TICKS),
    .WARN_TICKS   (WARN_TICKS),
    .CNT_W        (CNT_W)
  ) u_cnt (
    .clk_i      (clk_i),
    .arst_ni    (arst_ni),
    .tick_i     (tick_i),
    .dbg_halt_i (dbg_halt_i),
    .pause_cfg_i(pause_cfg_i),
    .en_i       (en),
    .clr_i      (clr),
    .count_o    (count),
    .run_o      (run),
    .expired_o  (expired),
    .nmi_o      (nmi_o),
    .rst_req_o  (rst_req_o)
  );

endmodule

// File: rtl/kwdt_chk.sv
module kwdt_chk #(
  parameter int unsigned TIMEOUT_TICKS = 2048,
  parameter int unsigned WARN_TICKS    = 1792,
  parameter int unsigned CNT_W         = 12
) (
  input logic             clk_i,
  input logic             arst_ni,
  input logic             tick_i,
  input logic             dbg_halt_i,
  input logic             pause_cfg_i,
  input logic             en,
  input logic             kick,
  input logic             expired,
  input logic [CNT_W-1:0] count,
  input logic             nmi_o,
  input logic             rst_req_o
);

  localparam logic [CNT_W-1:0] WARN_C = CNT_W'(WARN_TICKS);
  localparam logic [CNT_W-1:0] TO_C   = CNT_W'(TIMEOUT_TICKS);

  // R4
  off_holds_zero_chk: assert property (@(posedge clk_i) disable iff (!arst_ni)
    (!en && !expired) |-> count == '0);

  // R2
  step_needs_tick_chk: assert property (@(posedge clk_i) disable iff (!arst_ni)
    (count != $past(count) && count != '0) |-> ($past(tick_i) && $past(en)));

  // R6
  kick_clears_chk: assert property (@(posedge clk_i) disable iff (!arst_ni)
    (kick && !expired) |=> count == '0);

  // R7
  nmi_at_warn_chk: assert property (@(posedge clk_i) disable iff (!arst_ni)
    nmi_o |-> count == WARN_C);

  // R8
  rst_at_timeout_chk: assert property (@(posedge clk_i) disable iff (!arst_ni)
    rst_req_o |-> (count == TO_C && expired));

  // R8
  frozen_after_exp_chk: assert property (@(posedge clk_i) disable iff (!arst_ni)
    expired |=> (!rst_req_o && !nmi_o && $stable(count)));

  // R9
  debug_pause_chk: assert property (@(posedge clk_i) disable iff (!arst_ni)
    (pause_cfg_i && dbg_halt_i) |=> (count == $past(count) || count == '0));

  // R7
  pulses_apart_chk: assert property (@(posedge clk_i) disable iff (!arst_ni)
    $onehot0({nmi_o, rst_req_o}));

endmodule

bind kwdt_top kwdt_chk #(
  .TIMEOUT_TICKS(TIMEOUT_TICKS),
  .WARN_TICKS   (WARN_TICKS),
  .CNT_W        (CNT_W)
) u_chk (
  .clk_i      (clk_i),
  .arst_ni    (arst_ni),
  .tick_i     (tick_i),
  .dbg_halt_i (dbg_halt_i),
  .pause_cfg_i(pause_cfg_i),
  .en         (en),
  .kick       (evt.kick),
  .expired    (expired),
  .count      (count),
  .nmi_o      (nmi_o),
  .rst_req_o  (rst_req_o)
);

// File: tb/kwdt_top_tb.sv
module kwdt_top_tb;

  localparam int CLK_PERIOD = 10;
  localparam int TO   = 64;
  localparam int WN   = 48;
  localparam int AW   = 4;
  localparam int DW   = 16;
  localparam int WDOG = 20000;

  logic          clk = 1'b0;
  logic          arst_n = 1'b0;
  logic          tick;
  logic          halt = 1'b0;
  logic          pause = 1'b0;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic          nmi, rst_req;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int tick_div = 1;
  int nmi_seen = 0;
  int rst_seen = 0;
  bit done = 1'b0;

  // reference model state
  int m_en, m_arm, m_cnt, m_exp;
  bit exp_nmi, exp_rst;

  always #(CLK_PERIOD/2) clk = ~clk;

  kwdt_top #(.TIMEOUT_TICKS(TO), .WARN_TICKS(WN), .ADDR_W(AW), .DATA_W(DW)) u_dut (
    .clk_i(clk), .arst_ni(arst_n), .tick_i(tick), .dbg_halt_i(halt),
    .pause_cfg_i(pause), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .nmi_o(nmi), .rst_req_o(rst_req)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // tick pattern, changed away from the active edge
  always @(negedge clk) begin
    cyc++;
    tick <= (tick_div <= 1) ? 1'b1 : ((cyc % tick_div) == 0);
  end
  initial tick = 1'b0;

  // behavioural reference model, stepped on the same edge as the design
  always @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      m_en = 0; m_arm = 0; m_cnt = 0; m_exp = 0;
      exp_nmi = 0; exp_rst = 0;
    end else begin
      bit k_on, k_off, go_on, go_off, kick, run;
      k_on   = wr_en && wr_addr == 0 && wr_data == 16'hEABE;
      k_off  = wr_en && wr_addr == 0 && wr_data == 16'hDEAD;
      go_on  = wr_en && wr_addr == 1 && wr_data[0] && m_arm == 1;
      go_off = wr_en && wr_addr == 1 && wr_data[1] && m_arm == 2;
      kick   = wr_en && wr_addr == 2;
      run    = m_en != 0 && tick && !(pause && halt);
      exp_nmi = 0; exp_rst = 0;
      if (m_exp == 0) begin
        if (kick || go_off) m_cnt = 0;
        else if (run) begin
          m_cnt = m_cnt + 1;
          if (m_cnt == WN) exp_nmi = 1;
          if (m_cnt == TO) begin exp_rst = 1; m_exp = 1; end
        end
      end
      if (go_on) m_en = 1;
      else if (go_off) m_en = 0;
      if (k_on) m_arm = 1;
      else if (k_off) m_arm = 2;
      else if (wr_en) m_arm = 0;
    end
  end

  // compare every cycle away from the edge
  always @(negedge clk) begin
    if (arst_n && !done) begin
      check("R7 nmi_o vs model", int'(nmi), int'(exp_nmi));
      check("R8 rst_req_o vs model", int'(rst_req), int'(exp_rst));
      if (nmi) nmi_seen++;
      if (rst_req) rst_seen++;
    end
  end

  always @(posedge clk) begin
    if (cyc > WDOG && !done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected<%0d", cyc, WDOG);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic run(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = AW'(a); wr_data = DW'(d);
    @(negedge clk);
    wr_en = 1'b0; wr_addr = '0; wr_data = '0;
  endtask

  task automatic clear_seen();
    nmi_seen = 0; rst_seen = 0;
  endtask

  task automatic do_reset();
    @(negedge clk); arst_n = 1'b0;
    run(2);
    arst_n = 1'b1;
  endtask

  initial begin
    run(3);
    arst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 nmi after reset", int'(nmi), 0);
    check("R1 rst_req after reset", int'(rst_req), 0);
    clear_seen(); run(100);
    check("R1 disabled nmi count", nmi_seen, 0);

    // R5 command without key, and key broken by another write
    wr(1, 1); clear_seen(); run(100);
    check("R5 bare command nmi count", nmi_seen, 0);
    wr(0, 16'hEABE); wr(2, 0); wr(1, 1); clear_seen(); run(100);
    check("R5 broken key nmi count", nmi_seen, 0);

    // R3 proper enable, R6 restart
    wr(0, 16'hEABE); wr(1, 1); clear_seen(); run(40);
    check("R3 before warn nmi count", nmi_seen, 0);
    wr(2, 0); run(40);
    check("R6 restart kept nmi away", nmi_seen, 0);
    run(20);
    check("R7 warning pulse count", nmi_seen, 1);
    check("R7 no reset before timeout", rst_seen, 0);
    wr(2, 0);

    // R9 debug pause
    pause = 1'b1; halt = 1'b1; clear_seen(); run(200);
    check("R9 paused nmi count", nmi_seen, 0);
    pause = 1'b0; clear_seen(); run(50);
    check("R9 halt alone keeps counting", nmi_seen, 1);
    halt = 1'b0; wr(2, 0);

    // R2 sparse ticks
    tick_div = 4; clear_seen(); run(150);
    check("R2 sparse ticks before warn", nmi_seen, 0);
    run(60);
    check("R2 sparse ticks reach warn", nmi_seen, 1);
    tick_div = 1; wr(2, 0);

    // R8 expiry and freeze
    clear_seen(); run(100);
    check("R8 expiry nmi count", nmi_seen, 1);
    check("R8 expiry reset count", rst_seen, 1);
    wr(2, 0); wr(0, 16'hDEAD); wr(1, 2); wr(0, 16'hEABE); wr(1, 1); run(150);
    check("R8 frozen nmi count", nmi_seen, 1);
    check("R8 frozen reset count", rst_seen, 1);

    // R4 disable rules
    do_reset(); @(negedge clk);
    check("R1 nmi after second reset", int'(nmi), 0);
    wr(0, 16'hEABE); wr(1, 1);
    wr(0, 16'hEABE); wr(1, 2); clear_seen(); run(55);
    check("R4 wrong key leaves it running", nmi_seen, 1);
    wr(2, 0); wr(0, 16'hDEAD); wr(1, 2); clear_seen(); run(150);
    check("R4 disabled nmi count", nmi_seen, 0);
    check("R4 disabled reset count", rst_seen, 0);
    wr(0, 16'hEABE); wr(1, 1); clear_seen(); run(70);
    check("R3 re-enable reaches warn", nmi_seen, 1);
    check("R3 re-enable reaches timeout", rst_seen, 1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule